// File: doc/BRIEF.md
# Cell-Level Receive Slave with Two-Cell Queue

This block is the receive half of a cell-level slave on a UTOPIA Level 2 bus. An ATM master places cells on an 8-bit byte lane. It marks the first byte of each cell with a start flag and qualifies every byte with an active-low enable. The slave packs the bytes into 32-bit words. Each cell is padded up to a word boundary. The queue holds two whole cells, and a host drains it one word at a time through a read strobe.

The expected cell length is programmable. It is the standard 53 bytes plus an extra-header count of 0 to 11. The slave advertises a free cell slot to the master and raises its ready output only when a whole cell has landed. Byte order inside a word is selectable. In multi-PHY mode the slave answers only to its own programmed address. Clearing the enable input holds the whole receiver in reset. Everything runs on one clock.

The writer is a state machine with three states. W_IDLE waits for a start byte. W_FILL collects a cell. W_DROP discards a cell that arrived with no free slot. The writer moves from W_IDLE or W_DROP to W_FILL on a start byte when a slot is free. It moves from W_IDLE or W_DROP to W_DROP on a start byte when no slot is free. It stays in W_FILL on a body byte, and also on a start byte, which restarts the cell. It moves from W_FILL to W_IDLE on the last byte. The reader has two states. R_HEAD means it stands on word 0 of the oldest cell. R_BODY means it stands inside that cell. A pop moves the reader from R_HEAD to R_BODY. Popping the last word returns it to R_HEAD.

Top module: `cellq_rx`

## Requirements
- R1: After reset, and while cfg_enable is 0, the queue is empty: cell_ready, line_space and ovf_flag are 0. Clearing cfg_enable discards every queued and partial cell.
- R2: line_space is 1 exactly when three conditions hold: the receiver is enabled, it is selected, and the committed cells plus any cell being written number fewer than two.
- R3: A byte is taken at a rising edge where line_enb_n is 0 and the receiver is selected. In single mode (cfg_multi=0) the receiver is selected for any line_addr. In multi-PHY mode (cfg_multi=1) it is selected only when line_addr equals cfg_slave_id.
- R4: The cell length is 53 + cfg_extra bytes. A cfg_extra value above 11 counts as 11, so the length ranges from 53 to 64.
- R5: cell_ready is 0 while a cell is incomplete. It goes to 1 in the cycle after the edge that takes the last byte of a cell, and it stays at 1 while at least one complete cell is queued.
- R6: The queue holds two cells. A start byte that arrives while two cells are queued is dropped, together with the rest of its cell. It sets ovf_flag, which stays at 1 until cfg_enable is cleared.
- R7: Byte k of a cell goes to word k/4, lane k%4. With cfg_big_end=0, lane n occupies bits [8n+7:8n]. With cfg_big_end=1, lane n occupies bits [31-8n:24-8n]. Pad bytes read as 0. A cell spans ceil(length/4) words: 14 words at 53 bytes and 16 words at 64 bytes.
- R8: rd_data shows the current word of the oldest complete cell. rd_en advances to the next word, and after the last word the reader moves to the next cell. rd_en has no effect while no complete cell is queued.
- R9: A start byte taken while a cell is in progress drops the partial cell and starts a new cell in the same slot. soc_err is 1 for the single following cycle.
- R10: A byte without the start flag is ignored when no cell is in progress.
- R11: When a cell commits in the same cycle that the last word of another cell is read, the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the line side and the read side |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Receiver enable; 0 holds the receiver in reset |
| cfg_multi | input | 1 | 1 = multi-PHY address matching |
| cfg_slave_id | input | 5 | Own address used in multi-PHY mode |
| cfg_extra | input | 4 | Extra header bytes beyond 53 (0 to 11) |
| cfg_big_end | input | 1 | 1 = first byte in the most-significant lane |
| line_addr | input | 5 | Address from the master |
| line_space | output | 1 | Room for a whole cell |
| line_enb_n | input | 1 | Byte enable from the master, active low |
| line_soc | input | 1 | Marks the first byte of a cell |
| line_data | input | 8 | Byte from the master |
| rd_en | input | 1 | Pops one word of the oldest cell |
| rd_data | output | 32 | Current word of the oldest cell |
| cell_ready | output | 1 | At least one complete cell is queued |
| soc_err | output | 1 | One-cycle pulse after a mid-cell restart |
| ovf_flag | output | 1 | Sticky flag for a cell dropped on a full queue |

## Verification
Two functions can fall in the same cycle: the commit of an arriving cell and the pop of the final word of the queued cell. Both change the occupancy count. The bench queues one cell and reads all but its last word. It then streams a second cell and holds the read strobe high on exactly the edge that takes that cell's last byte. It judges the result through the ports: cell_ready must stay at 1, line_space must report a free slot, and the second cell must read back intact. Sweeps over every extra-header count and both byte orders, with expected words computed from the byte position, cover packing and padding.

// File: rtl/cellq_pkg.sv
package cellq_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FILL,
        W_DROP
    } wr_state_t;

    typedef enum logic {
        R_HEAD,
        R_BODY
    } rd_state_t;

endpackage

// File: rtl/cellq_store.sv
module cellq_store #(
    parameter int SLOTS  = 2,
    parameter int WORDS  = 16,
    parameter int IDX_W  = 4,
    parameter int SLOT_W = 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [IDX_W-1:0]  widx,
    input  logic [31:0]       wdata,
    input  logic [SLOT_W-1:0] rslot,
    input  logic [IDX_W-1:0]  ridx,
    output logic [31:0]       rdata
);

    logic [31:0] slot_rd [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [31:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (we && (wslot == SLOT_W'(s))) begin
                bank[widx] <= wdata;
            end
        end

        assign slot_rd[s] = bank[ridx];
    end

    assign rdata = slot_rd[rslot];

endmodule

// File: rtl/cellq_wr.sv
module cellq_wr
    import cellq_pkg::*;
#(
    parameter int SLOTS  = 2,
    parameter int LEN_W  = 7,
    parameter int IDX_W  = 4,
    parameter int SLOT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              take,
    input  logic              soc,
    input  logic [7:0]        din,
    input  logic              big_end,
    input  logic [LEN_W-1:0]  cell_len,
    input  logic              room,
    output logic              mem_we,
    output logic [SLOT_W-1:0] mem_slot,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [31:0]       mem_word,
    output logic              commit,
    output logic              soc_err,
    output logic              ovf_set,
    output logic              busy
);

    wr_state_t         st_q, st_n;
    logic [SLOT_W-1:0] slot_q;
    logic [LEN_W-1:0]  bcnt_q, bcnt_n;
    logic [31:0]       acc_q, acc_n;
    logic              err_q, err_n;

    logic              byte_we;
    logic [LEN_W-1:0]  pos;
    logic [1:0]        lane;
    logic [4:0]        shift;
    logic              last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= W_IDLE;
            slot_q <= '0;
            bcnt_q <= '0;
            acc_q  <= '0;
            err_q  <= 1'b0;
        end else if (!en) begin
            st_q   <= W_IDLE;
            slot_q <= '0;
            bcnt_q <= '0;
            acc_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            bcnt_q <= bcnt_n;
            err_q  <= err_n;
            if (byte_we) begin
                acc_q <= acc_n;
            end
            if (commit) begin
                slot_q <= (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        st_n    = st_q;
        byte_we = 1'b0;
        pos     = bcnt_q;
        ovf_set = 1'b0;
        err_n   = 1'b0;

        unique case (st_q)
            W_IDLE, W_DROP: begin
                if (take && soc) begin
                    if (room) begin
                        byte_we = 1'b1;
                        pos     = '0;
                    end else begin
                        ovf_set = 1'b1;
                        st_n    = W_DROP;
                    end
                end
            end
            W_FILL: begin
                if (take) begin
                    byte_we = 1'b1;
                    if (soc) begin
                        pos   = '0;
                        err_n = 1'b1;
                    end
                end
            end
            default: st_n = W_IDLE;
        endcase

        lane     = pos[1:0];
        shift    = {(big_end ? (2'd3 - lane) : lane), 3'b000};
        acc_n    = ((lane == 2'd0) ? 32'd0 : acc_q) | (32'(din) << shift);
        last     = (pos == (cell_len - LEN_W'(1)));
        mem_we   = byte_we && ((lane == 2'd3) || last);
        commit   = byte_we && last;

        if (byte_we) begin
            st_n = commit ? W_IDLE : W_FILL;
        end
        if (commit) begin
            bcnt_n = '0;
        end else if (byte_we) begin
            bcnt_n = pos + LEN_W'(1);
        end else begin
            bcnt_n = bcnt_q;
        end

        mem_slot = slot_q;
        mem_idx  = IDX_W'(pos >> 2);
        mem_word = acc_n;
        soc_err  = err_q;
        busy     = (st_q == W_FILL);
    end

endmodule

// File: rtl/cellq_rd.sv
module cellq_rd
    import cellq_pkg::*;
#(
    parameter int SLOTS  = 2,
    parameter int IDX_W  = 4,
    parameter int SLOT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rd_en,
    input  logic              have_cell,
    input  logic [IDX_W:0]    cell_words,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              done
);

    rd_state_t         st_q, st_n;
    logic [SLOT_W-1:0] slot_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pop;
    logic              last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= R_HEAD;
            slot_q <= '0;
            idx_q  <= '0;
        end else if (!en) begin
            st_q   <= R_HEAD;
            slot_q <= '0;
            idx_q  <= '0;
        end else begin
            st_q <= st_n;
            if (pop) begin
                if (last) begin
                    idx_q  <= '0;
                    slot_q <= (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // next state and outputs
    always_comb begin
        pop  = rd_en && have_cell;
        last = ({1'b0, idx_q} == (cell_words - 1'b1));
        st_n = st_q;
        unique case (st_q)
            R_HEAD: if (pop) st_n = last ? R_HEAD : R_BODY;
            R_BODY: if (pop && last) st_n = R_HEAD;
        endcase
        done    = pop && last;
        rd_slot = slot_q;
        rd_idx  = idx_q;
    end

endmodule

// File: rtl/cellq_rx.sv
module cellq_rx #(
    parameter int SLOTS     = 2,
    parameter int BASE_LEN  = 53,
    parameter int MAX_EXTRA = 11,
    parameter int ADDR_W    = 5,
    parameter int EXTRA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_multi,
    input  logic [ADDR_W-1:0] cfg_slave_id,
    input  logic [EXTRA_W-1:0] cfg_extra,
    input  logic              cfg_big_end,
    input  logic [ADDR_W-1:0] line_addr,
    output logic              line_space,
    input  logic              line_enb_n,
    input  logic              line_soc,
    input  logic [7:0]        line_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              cell_ready,
    output logic              soc_err,
    output logic              ovf_flag
);

    localparam int MAX_LEN   = BASE_LEN + MAX_EXTRA;
    localparam int MAX_WORDS = (MAX_LEN + 3) / 4;
    localparam int LEN_W     = $clog2(MAX_LEN + 1);
    localparam int IDX_W     = $clog2(MAX_WORDS);
    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W     = $clog2(SLOTS + 1);

    logic [LEN_W-1:0]  cell_len;
    logic [IDX_W:0]    cell_words;
    logic              sel;
    logic              take;
    logic              room;
    logic [CNT_W-1:0]  occ_q;

    logic              wr_we;
    logic [SLOT_W-1:0] wr_slot;
    logic [IDX_W-1:0]  wr_idx;
    logic [31:0]       wr_word;
    logic              wr_commit;
    logic              wr_ovf;
    logic              wr_busy;
    logic [SLOT_W-1:0] rd_slot;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_done;

    always_comb begin
        if (int'(cfg_extra) > MAX_EXTRA) begin
            cell_len = LEN_W'(MAX_LEN);
        end else begin
            cell_len = LEN_W'(BASE_LEN) + LEN_W'(cfg_extra);
        end
        cell_words = (IDX_W + 1)'((int'(cell_len) + 3) / 4);
    end

    assign sel        = !cfg_multi || (line_addr == cfg_slave_id);
    assign take       = cfg_enable && sel && !line_enb_n;
    assign room       = (int'(occ_q) < SLOTS);
    assign line_space = cfg_enable && sel && ((int'(occ_q) + int'(wr_busy)) < SLOTS);
    assign cell_ready = (occ_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q    <= '0;
            ovf_flag <= 1'b0;
        end else if (!cfg_enable) begin
            occ_q    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            occ_q    <= occ_q + CNT_W'(wr_commit) - CNT_W'(rd_done);
            ovf_flag <= ovf_flag | wr_ovf;
        end
    end

    cellq_wr #(
        .SLOTS (SLOTS),
        .LEN_W (LEN_W),
        .IDX_W (IDX_W),
        .SLOT_W(SLOT_W)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_enable),
        .take    (take),
        .soc     (line_soc),
        .din     (line_data),
        .big_end (cfg_big_end),
        .cell_len(cell_len),
        .room    (room),
        .mem_we  (wr_we),
        .mem_slot(wr_slot),
        .mem_idx (wr_idx),
        .mem_word(wr_word),
        .commit  (wr_commit),
        .soc_err (soc_err),
        .ovf_set (wr_ovf),
        .busy    (wr_busy)
    );

    cellq_store #(
        .SLOTS (SLOTS),
        .WORDS (MAX_WORDS),
        .IDX_W (IDX_W),
        .SLOT_W(SLOT_W)
    ) u_store (
        .clk  (clk),
        .we   (wr_we),
        .wslot(wr_slot),
        .widx (wr_idx),
        .wdata(wr_word),
        .rslot(rd_slot),
        .ridx (rd_idx),
        .rdata(rd_data)
    );

    cellq_rd #(
        .SLOTS (SLOTS),
        .IDX_W (IDX_W),
        .SLOT_W(SLOT_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_enable),
        .rd_en     (rd_en),
        .have_cell (cell_ready),
        .cell_words(cell_words),
        .rd_slot   (rd_slot),
        .rd_idx    (rd_idx),
        .done      (rd_done)
    );

endmodule

// File: rtl/cellq_rx_chk.sv
module cellq_rx_chk #(
    parameter int SLOTS = 2,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             line_space,
    input logic             line_soc,
    input logic             cell_ready,
    input logic             soc_err,
    input logic             ovf_flag,
    input logic             take,
    input logic             commit,
    input logic             done,
    input logic [CNT_W-1:0] count
);

    a_r1_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !cell_ready);

    a_r2_no_space_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) == SLOTS) |-> !line_space);

    a_r5_ready_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cell_ready) |-> $past(commit));

    a_r6_no_commit_into_full: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (int'(count) < SLOTS));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && cfg_enable) |=> ovf_flag);

    a_r8_pop_needs_cell: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cell_ready);

    a_r9_err_follows_soc: assert property (@(posedge clk) disable iff (!rst_n)
        soc_err |-> $past(take && line_soc));

    a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= SLOTS);

endmodule

bind cellq_rx cellq_rx_chk #(
    .SLOTS(SLOTS),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_enable(cfg_enable),
    .line_space(line_space),
    .line_soc  (line_soc),
    .cell_ready(cell_ready),
    .soc_err   (soc_err),
    .ovf_flag  (ovf_flag),
    .take      (take),
    .commit    (wr_commit),
    .done      (rd_done),
    .count     (occ_q)
);

// File: tb/cellq_rx_test.sv
module cellq_rx_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable, cfg_multi, cfg_big_end;
    logic [4:0]  cfg_slave_id, line_addr;
    logic [3:0]  cfg_extra;
    logic        line_space, line_enb_n, line_soc;
    logic [7:0]  line_data;
    logic        rd_en;
    logic [31:0] rd_data;
    logic        cell_ready, soc_err, ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    cellq_rx uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_multi(cfg_multi),
        .cfg_slave_id(cfg_slave_id), .cfg_extra(cfg_extra), .cfg_big_end(cfg_big_end),
        .line_addr(line_addr), .line_space(line_space), .line_enb_n(line_enb_n),
        .line_soc(line_soc), .line_data(line_data), .rd_en(rd_en), .rd_data(rd_data),
        .cell_ready(cell_ready), .soc_err(soc_err), .ovf_flag(ovf_flag)
    );

    function automatic logic [7:0] bval(int seed, int k);
        return 8'(seed * 37 + k * 11 + 1);
    endfunction

    function automatic int cur_len(int ex);
        return 53 + ((ex > 11) ? 11 : ex);
    endfunction

    function automatic logic [31:0] expw(int seed, int len, int big, int w);
        logic [31:0] r = '0;
        for (int lane = 0; lane < 4; lane++) begin
            int k = 4 * w + lane;
            logic [7:0] b = (k < len) ? bval(seed, k) : 8'd0;
            int sh = 8 * ((big != 0) ? (3 - lane) : lane);
            r = r | (32'(b) << sh);
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at the current falling edge, then wait for the next one
    task automatic tick(logic enb_n, logic soc, logic [7:0] d, logic rd);
        line_enb_n = enb_n;
        line_soc   = soc;
        line_data  = d;
        rd_en      = rd;
        @(negedge clk);
    endtask

    task automatic send_bytes(int seed, int from, int upto);
        for (int k = from; k < upto; k++) begin
            tick(1'b0, (k == 0), bval(seed, k), 1'b0);
        end
    endtask

    task automatic read_cell(string tag, int seed, int len, int big);
        for (int w = 0; w < (len + 3) / 4; w++) begin
            check(tag, rd_data, expw(seed, len, big, w));
            tick(1'b1, 1'b0, 8'h00, 1'b1);
        end
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int len;
        rst_n = 1'b0;
        cfg_enable = 1'b0; cfg_multi = 1'b0; cfg_big_end = 1'b0;
        cfg_slave_id = 5'd0; cfg_extra = 4'd0; line_addr = 5'd0;
        line_enb_n = 1'b1; line_soc = 1'b0; line_data = 8'h00; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1'b1, 1'b0, 8'h00, 1'b0);

        // R1 reset state
        check("R1 ready", 32'(cell_ready), 0);
        check("R1 space", 32'(line_space), 0);
        check("R1 ovf", 32'(ovf_flag), 0);
        check("R9 err idle", 32'(soc_err), 0);

        cfg_enable = 1'b1;
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R2 space empty", 32'(line_space), 1);

        // R4 R5 R7 sweep over lengths and byte orders
        for (int ex = 0; ex < 14; ex++) begin
            for (int big = 0; big < 2; big++) begin
                int seed = ex * 2 + big + 3;
                cfg_extra   = 4'(ex);
                cfg_big_end = big[0];
                len = cur_len(ex);
                send_bytes(seed, 0, len - 1);
                check("R5 partial", 32'(cell_ready), 0);
                send_bytes(seed, len - 1, len);
                check("R5 complete", 32'(cell_ready), 1);
                read_cell("R7 R4 words", seed, len, big);
                check("R8 drained", 32'(cell_ready), 0);
            end
        end

        cfg_extra = 4'd0; cfg_big_end = 1'b0; len = 53;

        // R6 two cells fill the queue, third is dropped
        send_bytes(101, 0, len);
        send_bytes(102, 0, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R2 space full", 32'(line_space), 0);
        check("R6 ovf clear", 32'(ovf_flag), 0);
        send_bytes(103, 0, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R6 ovf set", 32'(ovf_flag), 1);
        read_cell("R6 first", 101, len, 0);
        read_cell("R6 second", 102, len, 0);
        check("R6 empty", 32'(cell_ready), 0);
        check("R2 space again", 32'(line_space), 1);
        check("R6 ovf sticky", 32'(ovf_flag), 1);

        // R8 reading an empty queue does nothing
        repeat (3) tick(1'b1, 1'b0, 8'h00, 1'b1);
        send_bytes(104, 0, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        read_cell("R8 after empty pops", 104, len, 0);

        // R9 restart mid-cell
        send_bytes(105, 0, 20);
        send_bytes(106, 0, 1);
        check("R9 err pulse", 32'(soc_err), 1);
        send_bytes(106, 1, 2);
        check("R9 err one cycle", 32'(soc_err), 0);
        send_bytes(106, 2, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        read_cell("R9 restarted cell", 106, len, 0);
        check("R9 single cell", 32'(cell_ready), 0);

        // R10 stray bytes while idle
        for (int k = 0; k < 10; k++) tick(1'b0, 1'b0, 8'hA5, 1'b0);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R10 no cell", 32'(cell_ready), 0);
        check("R10 space", 32'(line_space), 1);
        send_bytes(107, 0, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        read_cell("R10 clean cell", 107, len, 0);

        // R3 multi-PHY selection
        cfg_multi = 1'b1; cfg_slave_id = 5'd5; line_addr = 5'd3;
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R3 space other addr", 32'(line_space), 0);
        send_bytes(108, 0, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R3 other addr ignored", 32'(cell_ready), 0);
        line_addr = 5'd5;
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R3 space own addr", 32'(line_space), 1);
        send_bytes(109, 0, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R3 own addr taken", 32'(cell_ready), 1);
        read_cell("R3 own cell", 109, len, 0);
        cfg_multi = 1'b0; line_addr = 5'd17;

        // R11 commit and final pop in the same cycle
        send_bytes(110, 0, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        for (int w = 0; w < 13; w++) begin
            check("R11 head words", rd_data, expw(110, len, 0, w));
            tick(1'b1, 1'b0, 8'h00, 1'b1);
        end
        send_bytes(111, 0, len - 1);
        check("R11 space while filling", 32'(line_space), 0);
        check("R11 last word", rd_data, expw(110, len, 0, 13));
        tick(1'b0, 1'b0, bval(111, len - 1), 1'b1);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R11 ready kept", 32'(cell_ready), 1);
        check("R11 one slot free", 32'(line_space), 1);
        read_cell("R11 second cell", 111, len, 0);
        check("R11 empty", 32'(cell_ready), 0);

        // R1 disable discards queued cell and clears overflow
        send_bytes(112, 0, len);
        send_bytes(113, 0, 9);
        check("R1 ready before disable", 32'(cell_ready), 1);
        cfg_enable = 1'b0;
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R1 ready after disable", 32'(cell_ready), 0);
        check("R1 space after disable", 32'(line_space), 0);
        check("R1 ovf after disable", 32'(ovf_flag), 0);
        cfg_enable = 1'b1;
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        check("R1 ready re-enabled", 32'(cell_ready), 0);
        check("R1 space re-enabled", 32'(line_space), 1);
        send_bytes(114, 0, len);
        tick(1'b1, 1'b0, 8'h00, 1'b0);
        read_cell("R1 fresh cell", 114, len, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule